// File: doc/BRIEF.md
# Per-Channel Loopback Path Controller

This block sits between the system-side framer pins and the line-side analog circuits of an eight-channel T1/E1 line interface. For every channel it decides where the dual-rail transmit traffic (clock, positive rail, negative rail) goes and where the receive outputs get their traffic from. Four channel modes are supported. In normal mode traffic passes straight through. Digital loopback turns the system transmit traffic back onto the system receive outputs. Remote loopback turns the recovered line traffic back toward the line. All-ones insertion sends a continuous mark pattern to the line.

Each channel is steered by one of two control sources, and a single select input picks the source. Under host control, two write-only registers hold one bit per channel: the remote-loop register at address 0x02 and the digital-loop register at address 0x0C. Under pin control, one active-low pin per channel requests remote loopback. The all-ones request pins are honoured under both sources, but their priority against remote loopback differs between the two. A delay stage on the receive output side stands in for the jitter attenuator. It can be bypassed per channel, and its depth is a parameter.

Every signal is sampled in the block's clock domain. Transmit and recovered clocks are routed like data, and the all-ones pattern is paced by rising edges of the master clock input as seen in that domain.

Top module: `lpc_loop_ctrl`

## Requirements
- R1: After reset both control registers hold zero, so under host control every channel is in normal mode.
- R2: In normal mode the line outputs equal the system transmit inputs and the system receive outputs equal the line receive inputs (delay stage bypassed). This holds bit for bit for every channel.
- R3: Under host control (`host_ctl`=1), bit n of the register at address 0x0C sets digital loopback on channel n. The system receive outputs then carry that channel's system transmit clock and rails, and its line receive inputs are ignored. The system transmit traffic still goes out on the line outputs.
- R4: Under pin control (`host_ctl`=0), digital loopback is never active, whatever the 0x0C register holds.
- R5: Under pin control, driving `hw_rloop_n[n]` low sets remote loopback on channel n. The line outputs then carry the line receive clock and rails, and the system transmit inputs are ignored. Under host control these pins have no effect.
- R6: Under host control, bit n of the register at address 0x02 sets remote loopback on channel n. A write lands at the clock edge that samples `reg_we`, and under pin control the register has no effect.
- R7: Under pin control, remote loopback takes precedence over an all-ones request on the same channel.
- R8: Under host control, an all-ones request takes precedence over remote loopback on the same channel.
- R9: All-ones and digital loopback may be active together. The line gets the all-ones pattern while the system transmit traffic is still looped to the system receive outputs.
- R10: While all-ones is in effect, the line clock output follows `mclk`. Exactly one line rail is high at any time: positive right after reset. The high rail swaps at the clock edge that first samples `mclk` high after it was low.
- R11: With `ja_en[n]`=1, channel n's system receive outputs equal its selected receive source delayed by JA_DEPTH clock cycles.
- R12: A write to any address other than 0x02 and 0x0C changes no channel's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ctl | input | 1 | 1: registers control the channels; 0: pins control them |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | NCH | Register write data, bit n for channel n |
| hw_rloop_n | input | NCH | Remote loopback request pins, active low, pin control only |
| ones_req | input | NCH | All-ones insertion request per channel |
| ja_en | input | NCH | Delay stage enable per channel |
| mclk | input | 1 | Master clock that paces the all-ones pattern |
| sys_tclk | input | NCH | System transmit clock per channel |
| sys_tpos | input | NCH | System transmit positive rail |
| sys_tneg | input | NCH | System transmit negative rail |
| lin_rclk | input | NCH | Recovered line clock per channel |
| lin_rpos | input | NCH | Recovered line positive rail |
| lin_rneg | input | NCH | Recovered line negative rail |
| lin_tclk | output | NCH | Line transmit clock per channel |
| lin_tpos | output | NCH | Line transmit positive rail |
| lin_tneg | output | NCH | Line transmit negative rail |
| sys_rclk | output | NCH | System receive clock per channel |
| sys_rpos | output | NCH | System receive positive rail |
| sys_rneg | output | NCH | System receive negative rail |

## Verification
The mode sweep gives each channel a different mode from the others, rotating so that every channel meets all eight combinations of digital loop, remote loop and all-ones under both control sources. The sweep is run with distinct bit patterns on the system transmit side and the line receive side. Because the two sources never match, each output shows whether it took the transmit, the recovered or the all-ones source. During the sweep the pins disagree with the registers: under host control they request the opposite loop, and under pin control the register holds the complement. This exposes a wrong control source or a wrong priority. Separate runs step the master clock to follow the rail alternation, feed a changing sequence through the delay stage to measure its latency, and write a stray address to show that it leaves the channels alone.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  // One dual-rail lane: clock, positive mark, negative mark.
  typedef struct packed {
    logic ck;
    logic p;
    logic n;
  } rail_t;

  // Resolved per-channel decision after precedence has been applied.
  typedef struct packed {
    logic dloop;   // system transmit traffic turned back to system receive
    logic rloop;   // recovered traffic turned back to the line
    logic ones;    // line gets the all-ones pattern
  } chan_sel_t;

  function automatic rail_t mk_rail(input logic ck, input logic p, input logic n);
    rail_t r;
    r.ck = ck;
    r.p  = p;
    r.n  = n;
    return r;
  endfunction

endpackage

// File: rtl/lpc_rst_sync.sv
module lpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nx;
    end
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpc_regs.sv
module lpc_regs #(
  parameter int                NCH        = 8,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] RLOOP_ADDR = 'h02,
  parameter logic [ADDR_W-1:0] DLOOP_ADDR = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NCH-1:0]    reg_wdata,
  output logic [NCH-1:0]    rloop_q,
  output logic [NCH-1:0]    dloop_q
);

  logic           ld_rloop;
  logic           ld_dloop;
  logic [NCH-1:0] rloop_nx;
  logic [NCH-1:0] dloop_nx;

  always_comb begin
    ld_rloop = reg_we && (reg_addr == RLOOP_ADDR);
    ld_dloop = reg_we && (reg_addr == DLOOP_ADDR);
    rloop_nx = ld_rloop ? reg_wdata : rloop_q;
    dloop_nx = ld_dloop ? reg_wdata : dloop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rloop_q <= '0;
    end else if (ld_rloop) begin
      rloop_q <= rloop_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dloop_q <= '0;
    end else if (ld_dloop) begin
      dloop_q <= dloop_nx;
    end
  end

endmodule

// File: rtl/lpc_ones_gen.sv
module lpc_ones_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk,
  output logic ones_pos,
  output logic ones_neg
);

  logic mclk_q;
  logic phase_q;
  logic mclk_rise;
  logic phase_nx;

  always_comb begin
    mclk_rise = mclk && !mclk_q;
    phase_nx  = !phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_q <= 1'b0;
    end else begin
      mclk_q <= mclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (mclk_rise) begin
      phase_q <= phase_nx;
    end
  end

  // Every bit is a mark; marks alternate between the rails.
  assign ones_pos = !phase_q;
  assign ones_neg = phase_q;

endmodule

// File: rtl/lpc_ja_stage.sv
module lpc_ja_stage
  import lpc_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bypass,
  input  rail_t din,
  output rail_t dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_pipe
      rail_t pipe_q  [DEPTH];
      rail_t pipe_nx [DEPTH];

      always_comb begin
        pipe_nx[0] = din;
        for (int s = 1; s < DEPTH; s++) begin
          pipe_nx[s] = pipe_q[s-1];
        end
      end

      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            pipe_q[s] <= '0;
          end else begin
            pipe_q[s] <= pipe_nx[s];
          end
        end
      end

      assign dout = bypass ? din : pipe_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/lpc_loop_ctrl.sv
module lpc_loop_ctrl
  import lpc_pkg::*;
#(
  parameter int                NCH        = 8,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] RLOOP_ADDR = 'h02,
  parameter logic [ADDR_W-1:0] DLOOP_ADDR = 'h0C,
  parameter int                JA_DEPTH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ctl,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NCH-1:0]    reg_wdata,
  input  logic [NCH-1:0]    hw_rloop_n,
  input  logic [NCH-1:0]    ones_req,
  input  logic [NCH-1:0]    ja_en,
  input  logic              mclk,
  input  logic [NCH-1:0]    sys_tclk,
  input  logic [NCH-1:0]    sys_tpos,
  input  logic [NCH-1:0]    sys_tneg,
  input  logic [NCH-1:0]    lin_rclk,
  input  logic [NCH-1:0]    lin_rpos,
  input  logic [NCH-1:0]    lin_rneg,
  output logic [NCH-1:0]    lin_tclk,
  output logic [NCH-1:0]    lin_tpos,
  output logic [NCH-1:0]    lin_tneg,
  output logic [NCH-1:0]    sys_rclk,
  output logic [NCH-1:0]    sys_rpos,
  output logic [NCH-1:0]    sys_rneg
);

  logic           rst_s_n;
  logic [NCH-1:0] rloop_q;
  logic [NCH-1:0] dloop_q;
  logic           ones_pos;
  logic           ones_neg;

  lpc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  lpc_regs #(
    .NCH        (NCH),
    .ADDR_W     (ADDR_W),
    .RLOOP_ADDR (RLOOP_ADDR),
    .DLOOP_ADDR (DLOOP_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rloop_q   (rloop_q),
    .dloop_q   (dloop_q)
  );

  lpc_ones_gen u_ones (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mclk     (mclk),
    .ones_pos (ones_pos),
    .ones_neg (ones_neg)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      chan_sel_t sel;
      rail_t     tx_in;
      rail_t     rx_in;
      rail_t     ones_lane;
      rail_t     line_out;
      rail_t     rx_src;
      rail_t     rx_out;

      // Precedence between loopback and all-ones depends on the source.
      always_comb begin
        if (host_ctl) begin
          sel.dloop = dloop_q[i];
          sel.ones  = ones_req[i];
          sel.rloop = rloop_q[i] && !ones_req[i];
        end else begin
          sel.dloop = 1'b0;
          sel.rloop = !hw_rloop_n[i];
          sel.ones  = ones_req[i] && hw_rloop_n[i];
        end
      end

      always_comb begin
        tx_in     = mk_rail(sys_tclk[i], sys_tpos[i], sys_tneg[i]);
        rx_in     = mk_rail(lin_rclk[i], lin_rpos[i], lin_rneg[i]);
        ones_lane = mk_rail(mclk, ones_pos, ones_neg);
        if (sel.ones) begin
          line_out = ones_lane;
        end else if (sel.rloop) begin
          line_out = rx_in;
        end else begin
          line_out = tx_in;
        end
        rx_src = sel.dloop ? tx_in : rx_in;
      end

      lpc_ja_stage #(.DEPTH(JA_DEPTH)) u_ja (
        .clk    (clk),
        .rst_n  (rst_s_n),
        .bypass (!ja_en[i]),
        .din    (rx_src),
        .dout   (rx_out)
      );

      assign lin_tclk[i] = line_out.ck;
      assign lin_tpos[i] = line_out.p;
      assign lin_tneg[i] = line_out.n;
      assign sys_rclk[i] = rx_out.ck;
      assign sys_rpos[i] = rx_out.p;
      assign sys_rneg[i] = rx_out.n;
    end
  endgenerate

endmodule

// File: rtl/lpc_loop_ctrl_chk.sv
module lpc_loop_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_s_n,
  input logic           host_ctl,
  input logic [NCH-1:0] hw_rloop_n,
  input logic [NCH-1:0] ones_req,
  input logic [NCH-1:0] ja_en,
  input logic           mclk,
  input logic [NCH-1:0] lin_rclk,
  input logic [NCH-1:0] lin_rpos,
  input logic [NCH-1:0] lin_rneg,
  input logic [NCH-1:0] lin_tclk,
  input logic [NCH-1:0] lin_tpos,
  input logic [NCH-1:0] lin_tneg,
  input logic [NCH-1:0] sys_rpos,
  input logic [NCH-1:0] sys_rneg,
  input logic           ones_pos,
  input logic           ones_neg
);

  logic mclk_seen;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mclk_seen <= 1'b0;
    end else begin
      mclk_seen <= mclk;
    end
  end

  // R4: under pin control the receive outputs always follow the line
  a_r4_hw_no_dloop: assert property (@(posedge clk) disable iff (!rst_s_n)
    !host_ctl |-> ((((sys_rpos ^ lin_rpos) | (sys_rneg ^ lin_rneg)) & ~ja_en) == '0));

  // R5: a low pin turns recovered traffic back to the line
  a_r5_hw_remote: assert property (@(posedge clk) disable iff (!rst_s_n)
    !host_ctl |-> ((((lin_tpos ^ lin_rpos) | (lin_tneg ^ lin_rneg) | (lin_tclk ^ lin_rclk))
                    & ~hw_rloop_n) == '0));

  // R7: all-ones only where the pin does not ask for remote loopback
  a_r7_hw_ones: assert property (@(posedge clk) disable iff (!rst_s_n)
    !host_ctl |-> (((lin_tclk ^ {NCH{mclk}}) | (lin_tpos ^ {NCH{ones_pos}}))
                   & ones_req & hw_rloop_n) == '0);

  // R8: under host control every all-ones request reaches the line
  a_r8_host_ones: assert property (@(posedge clk) disable iff (!rst_s_n)
    host_ctl |-> (((lin_tclk ^ {NCH{mclk}}) | (lin_tneg ^ {NCH{ones_neg}})) & ones_req) == '0);

  // R10: exactly one rail carries the mark
  a_r10_one_rail: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot({ones_pos, ones_neg}));

  // R10: the marked rail swaps on a master clock rise
  a_r10_swap: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mclk && !mclk_seen) |=> (ones_pos != $past(ones_pos)));

  // R10: and holds otherwise
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(mclk && !mclk_seen) |=> $stable(ones_pos));

endmodule

bind lpc_loop_ctrl lpc_loop_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .host_ctl   (host_ctl),
  .hw_rloop_n (hw_rloop_n),
  .ones_req   (ones_req),
  .ja_en      (ja_en),
  .mclk       (mclk),
  .lin_rclk   (lin_rclk),
  .lin_rpos   (lin_rpos),
  .lin_rneg   (lin_rneg),
  .lin_tclk   (lin_tclk),
  .lin_tpos   (lin_tpos),
  .lin_tneg   (lin_tneg),
  .sys_rpos   (sys_rpos),
  .sys_rneg   (sys_rneg),
  .ones_pos   (ones_pos),
  .ones_neg   (ones_neg)
);

// File: tb/lpc_loop_ctrl_test.sv
module lpc_loop_ctrl_test;

  localparam int NCH = 8;
  localparam int AW  = 8;
  localparam int D   = 2;

  logic           clk;
  logic           rst_n;
  logic           host_ctl;
  logic           reg_we;
  logic [AW-1:0]  reg_addr;
  logic [NCH-1:0] reg_wdata;
  logic [NCH-1:0] hw_rloop_n;
  logic [NCH-1:0] ones_req;
  logic [NCH-1:0] ja_en;
  logic           mclk;
  logic [NCH-1:0] sys_tclk, sys_tpos, sys_tneg;
  logic [NCH-1:0] lin_rclk, lin_rpos, lin_rneg;
  logic [NCH-1:0] lin_tclk, lin_tpos, lin_tneg;
  logic [NCH-1:0] sys_rclk, sys_rpos, sys_rneg;

  int errors = 0;
  int checks = 0;
  logic ph = 1'b0;

  lpc_loop_ctrl #(.NCH(NCH), .ADDR_W(AW), .JA_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .host_ctl(host_ctl), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hw_rloop_n(hw_rloop_n),
    .ones_req(ones_req), .ja_en(ja_en), .mclk(mclk),
    .sys_tclk(sys_tclk), .sys_tpos(sys_tpos), .sys_tneg(sys_tneg),
    .lin_rclk(lin_rclk), .lin_rpos(lin_rpos), .lin_rneg(lin_rneg),
    .lin_tclk(lin_tclk), .lin_tpos(lin_tpos), .lin_tneg(lin_tneg),
    .sys_rclk(sys_rclk), .sys_rpos(sys_rpos), .sys_rneg(sys_rneg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NCH-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic drive(input int p);
    logic [7:0] v;
    v = 8'(p);
    sys_tclk = 8'h0F ^ (v * 8'd3);
    sys_tpos = 8'h33 + v * 8'd17;
    sys_tneg = 8'hC6 ^ (v * 8'd5);
    lin_rclk = ~sys_tclk;
    lin_rpos = ~sys_tpos;
    lin_rneg = ~sys_tneg;
  endtask

  task automatic chk_pass(input string req);
    chk(req, lin_tclk, sys_tclk);
    chk(req, lin_tpos, sys_tpos);
    chk(req, lin_tneg, sys_tneg);
    chk(req, sys_rclk, lin_rclk);
    chk(req, sys_rpos, lin_rpos);
    chk(req, sys_rneg, lin_rneg);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [NCH-1:0] dlb, rlb, aob, e_dl, e_rl, e_ao;
    logic [NCH-1:0] et_ck, et_p, et_n, er_ck, er_p, er_n;
    logic [NCH-1:0] hist [0:15];

    rst_n = 1'b0; host_ctl = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    hw_rloop_n = '1; ones_req = '0; ja_en = '0; mclk = 1'b0;
    drive(0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state is normal mode; R2: straight pass-through
    drive(1); #1;
    chk_pass("R1");
    drive(6); #1;
    chk_pass("R2");

    // R12: a stray address leaves every channel alone
    wr(8'h05, '1);
    wr(8'h0D, '1);
    drive(3); #1;
    chk_pass("R12");

    // Mode sweep: channel i gets mode (cfg+i)%8, bit0 dloop, bit1 rloop, bit2 all-ones
    for (int h = 0; h < 2; h++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        for (int i = 0; i < NCH; i++) begin
          int m;
          m = (cfg + i) % 8;
          dlb[i] = m[0]; rlb[i] = m[1]; aob[i] = m[2];
        end
        host_ctl = h[0];
        wr(8'h0C, dlb);
        if (h == 1) begin
          wr(8'h02, rlb);
          hw_rloop_n = rlb;        // pins request the opposite: must be ignored
        end else begin
          wr(8'h02, ~rlb);         // register holds the complement: must be ignored
          hw_rloop_n = ~rlb;
        end
        ones_req = aob;
        if (h == 1) begin
          e_dl = dlb; e_ao = aob; e_rl = rlb & ~aob;
        end else begin
          e_dl = '0;  e_rl = rlb; e_ao = aob & ~rlb;
        end
        for (int p = 0; p < 8; p++) begin
          drive(p + 2 * cfg); #1;
          for (int i = 0; i < NCH; i++) begin
            if (e_ao[i]) begin
              et_ck[i] = mclk; et_p[i] = ~ph; et_n[i] = ph;
            end else if (e_rl[i]) begin
              et_ck[i] = lin_rclk[i]; et_p[i] = lin_rpos[i]; et_n[i] = lin_rneg[i];
            end else begin
              et_ck[i] = sys_tclk[i]; et_p[i] = sys_tpos[i]; et_n[i] = sys_tneg[i];
            end
            if (e_dl[i]) begin
              er_ck[i] = sys_tclk[i]; er_p[i] = sys_tpos[i]; er_n[i] = sys_tneg[i];
            end else begin
              er_ck[i] = lin_rclk[i]; er_p[i] = lin_rpos[i]; er_n[i] = lin_rneg[i];
            end
          end
          if (h == 1) begin
            chk("R3 R6 R8 R9 host line clk", lin_tclk, et_ck);
            chk("R3 R6 R8 R9 host line pos", lin_tpos, et_p);
            chk("R3 R6 R8 R9 host line neg", lin_tneg, et_n);
            chk("R3 R9 host rx clk", sys_rclk, er_ck);
            chk("R3 R9 host rx pos", sys_rpos, er_p);
            chk("R3 R9 host rx neg", sys_rneg, er_n);
          end else begin
            chk("R5 R7 pin line clk", lin_tclk, et_ck);
            chk("R5 R7 pin line pos", lin_tpos, et_p);
            chk("R5 R7 pin line neg", lin_tneg, et_n);
            chk("R4 pin rx clk", sys_rclk, er_ck);
            chk("R4 pin rx pos", sys_rpos, er_p);
            chk("R4 pin rx neg", sys_rneg, er_n);
          end
        end
      end
    end

    // R10: all-ones pacing by the master clock
    host_ctl = 1'b1;
    wr(8'h0C, '0);
    wr(8'h02, '0);
    ones_req = '1;
    #1;
    chk("R10 idle pos", lin_tpos, {NCH{~ph}});
    chk("R10 idle neg", lin_tneg, {NCH{ph}});
    for (int k = 0; k < 4; k++) begin
      mclk = 1'b1;
      @(negedge clk);
      ph = ~ph;
      #1;
      chk("R10 clk high", lin_tclk, '1);
      chk("R10 swap pos", lin_tpos, {NCH{~ph}});
      chk("R10 swap neg", lin_tneg, {NCH{ph}});
      @(negedge clk);
      mclk = 1'b0;
      @(negedge clk);
      #1;
      chk("R10 clk low", lin_tclk, '0);
      chk("R10 hold pos", lin_tpos, {NCH{~ph}});
    end
    ones_req = '0;

    // R11: delay stage latency
    ja_en = '1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      drive(k * 7 + 1);
      hist[k] = lin_rpos;
      #1;
      if (k >= D) begin
        chk("R11 delayed pos", sys_rpos, hist[k - D]);
      end
    end
    ja_en = '0;
    #1;
    chk("R11 bypass", sys_rpos, lin_rpos);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule